// File: doc/BRIEF.md
# Two-Slave Link Polling Master

This block is the command-level sequencer on the master end of a single half-duplex wire pair that is shared by two addressed slaves, numbered 0 and 1. It decides which control command goes out next and to which slave. It raises the link to each slave by repeating a link-reset command until that slave replies ready. Once a slave is up, the block polls it for data. It starts an outgoing frame only while the slave has reported free buffer space, and it queries that buffer state after the slave reports full. A slave may reboot only when it answers a poll, and the block then takes that slave back to link bring-up.

Character encoding, payload movement and host signalling belong to the neighbouring framing logic. That logic passes in each decoded control character as a slave number and a 4-bit code. It also reports when an outgoing frame has been fully sent and when an incoming frame has ended. In return it receives a command to transmit, a strobe to start an outgoing frame, a strobe to accept an incoming frame, and a strobe to release a delivered packet from its queue. The slave turns alternate. A slave that is not up takes a turn only when its link-reset retry period has run out, so a missing slave leaves almost all of the link time to the other one.

Top module: `lnk_poll_master`

## Requirements
- R1: After reset every strobe is low, `cmd_code` reads 0, `slv` reads 0, and the first action is a link-reset command (code 0xB) to slave 0.
- R2: A slave that is not up is sent link-reset (0xB) on its turn only when at least RETRY_CYC cycles have passed since the previous link-reset to that slave. A ready reply (0xF) from that slave marks it up.
- R3: Turns alternate between the two slaves. An up slave with no full-buffer report and no pending packet is sent a poll (0x5). A no-data reply (0x6) ends the turn.
- R4: A frame-start reply (0x1) to a poll produces a one-cycle `rx_accept`. The next turn begins only after `rx_done`.
- R5: While the current slave is up and not full, a pending packet (`tx_req` bit set) is started with `tx_start`. After `tx_done` the block waits for a reply, and an ack-with-room (0x8) produces `tx_release`.
- R6: An ack-full reply (0x9) to a frame also releases the packet. From then on that slave gets a buffer query (0xC) on each of its turns and no `tx_start`, until a query is answered with 0x8.
- R7: An ack-error reply (0xA) to a frame gives no `tx_release`, so the packet is started again on that slave's next turn.
- R8: A reboot reply (0x7) to a poll marks the slave not up, and its next link-reset comes no sooner than RETRY_CYC cycles later.
- R9: Characters from the other slave, and codes that are not valid answers to the outstanding command (including 0x7 after anything but a poll), are ignored. The reply timer keeps running through them.
- R10: TIMEOUT_CYC cycles without a valid reply end the turn. After MISS_LIMIT consecutive timeouts an up slave is marked not up, is sent only link-reset from then on, and the other slave gets the freed turns.
- R11: `cmd_valid`, `tx_start`, `rx_accept` and `tx_release` are one-cycle strobes, at most one at a time, and `slv` gives the slave they refer to. `cmd_code` is 0 whenever `cmd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A decoded control character is present |
| rx_slave | input | 1 | Slave number of the received character |
| rx_cmd | input | 4 | Code of the received character |
| tx_req | input | 2 | Per-slave flag: an outgoing packet is queued |
| tx_done | input | 1 | Outgoing frame fully sent |
| rx_done | input | 1 | Incoming frame ended |
| cmd_valid | output | 1 | Strobe: send `cmd_code` to slave `slv` |
| cmd_code | output | 4 | Command to send (0xB, 0x5 or 0xC) |
| tx_start | output | 1 | Strobe: start the queued frame to slave `slv` |
| rx_accept | output | 1 | Strobe: accept the incoming frame from slave `slv` |
| tx_release | output | 1 | Strobe: drop the delivered packet of slave `slv` |
| slv | output | 1 | Slave that the current strobe refers to |

## Verification
The bench builds the block with TIMEOUT_CYC = 8, RETRY_CYC = 40 and MISS_LIMIT = 3. At those values the link-reset cadence, several retry periods after a reboot, and the loss of a slave after three silent turns all fit into under two thousand cycles. A scripted pair of slaves runs each scenario: bring-up, polling with and without data, buffer exhaustion and recovery, error resend, reboot, junk characters and a slave dropping out. A behavioural model checks every output on every cycle.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

  localparam int NSLV = 2;

  typedef enum logic [3:0] {
    CMD_NONE        = 4'h0,
    CMD_FRAME_START = 4'h1,
    CMD_POLL        = 4'h5,
    CMD_NODATA      = 4'h6,
    CMD_REBOOT      = 4'h7,
    CMD_ACK_ROOM    = 4'h8,
    CMD_ACK_FULL    = 4'h9,
    CMD_ACK_ERR     = 4'hA,
    CMD_LINK_RESET  = 4'hB,
    CMD_ROOM_QUERY  = 4'hC,
    CMD_READY       = 4'hF
  } lnk_cmd_e;

  typedef enum logic [1:0] {
    ST_PICK = 2'd0,
    ST_WAIT = 2'd1,
    ST_XMIT = 2'd2,
    ST_RECV = 2'd3
  } lnk_state_e;

  // Which command the awaited reply belongs to
  typedef enum logic [1:0] {
    K_LINK  = 2'd0,
    K_POLL  = 2'd1,
    K_FRAME = 2'd2,
    K_QUERY = 2'd3
  } lnk_kind_e;

endpackage

// File: rtl/lnk_rst_sync.sv
module lnk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/lnk_reply_timer.sv
module lnk_reply_timer #(
  parameter int TIMEOUT_CYC = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expired
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic [TW-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q == TW'(TIMEOUT_CYC - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (!expired) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lnk_slave_track.sv
module lnk_slave_track #(
  parameter int RETRY_CYC  = 250000,
  parameter int MISS_LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_reset_sent,
  input  logic ev_reboot,
  input  logic ev_ready,
  input  logic ev_hit,
  input  logic ev_full,
  input  logic ev_room,
  input  logic ev_miss,
  output logic up,
  output logic full,
  output logic due
);
  localparam int RW = $clog2(RETRY_CYC + 1);
  localparam int MW = $clog2(MISS_LIMIT + 1);

  logic [RW-1:0] rty_q, rty_d;
  logic [MW-1:0] miss_q, miss_d;
  logic          up_d, full_d;

  assign due = (rty_q == '0);

  always_comb begin
    up_d   = up;
    full_d = full;
    miss_d = miss_q;
    if (ev_reboot) begin
      up_d   = 1'b0;
      full_d = 1'b0;
      miss_d = '0;
    end else if (ev_ready) begin
      up_d   = 1'b1;
      full_d = 1'b0;
      miss_d = '0;
    end else if (ev_miss && up) begin
      if (miss_q == MW'(MISS_LIMIT - 1)) begin
        up_d   = 1'b0;
        full_d = 1'b0;
        miss_d = '0;
      end else begin
        miss_d = miss_q + 1'b1;
      end
    end else begin
      if (ev_hit)  miss_d = '0;
      if (ev_full) full_d = 1'b1;
      if (ev_room) full_d = 1'b0;
    end
  end

  always_comb begin
    rty_d = rty_q;
    if (ev_reset_sent || ev_reboot) rty_d = RW'(RETRY_CYC - 1);
    else if (!due)                  rty_d = rty_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up     <= 1'b0;
      full   <= 1'b0;
      miss_q <= '0;
      rty_q  <= '0;
    end else begin
      up     <= up_d;
      full   <= full_d;
      miss_q <= miss_d;
      rty_q  <= rty_d;
    end
  end
endmodule

// File: rtl/lnk_poll_master.sv
module lnk_poll_master
  import lnk_pkg::*;
#(
  parameter int TIMEOUT_CYC = 12500,
  parameter int RETRY_CYC   = 250000,
  parameter int MISS_LIMIT  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic       rx_slave,
  input  logic [3:0] rx_cmd,
  input  logic [1:0] tx_req,
  input  logic       tx_done,
  input  logic       rx_done,
  output logic       cmd_valid,
  output logic [3:0] cmd_code,
  output logic       tx_start,
  output logic       rx_accept,
  output logic       tx_release,
  output logic       slv
);
  logic rst_q_n;
  lnk_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n));

  lnk_state_e st_q, st_d;
  lnk_kind_e  kind_q, kind_d;
  logic       cur_q, cur_d;
  logic [NSLV-1:0] up, full, due;
  logic       expired, hit, known, fin;
  logic       do_cmd, do_tx, do_acc, do_rel;
  lnk_cmd_e   code;
  logic       ev_reset_sent, ev_reboot, ev_ready, ev_hit, ev_full, ev_room, ev_miss;

  lnk_reply_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_q_n), .clr(st_q != ST_WAIT), .expired(expired)
  );

  for (genvar g = 0; g < NSLV; g++) begin : g_slv
    logic sel;
    assign sel = (cur_q == 1'(g));
    lnk_slave_track #(.RETRY_CYC(RETRY_CYC), .MISS_LIMIT(MISS_LIMIT)) u_trk (
      .clk(clk), .rst_n(rst_q_n),
      .ev_reset_sent(ev_reset_sent & sel), .ev_reboot(ev_reboot & sel),
      .ev_ready(ev_ready & sel), .ev_hit(ev_hit & sel),
      .ev_full(ev_full & sel), .ev_room(ev_room & sel), .ev_miss(ev_miss & sel),
      .up(up[g]), .full(full[g]), .due(due[g])
    );
  end

  assign hit = rx_valid && (rx_slave == cur_q);

  always_comb begin
    st_d = st_q; kind_d = kind_q; cur_d = cur_q;
    do_cmd = 1'b0; do_tx = 1'b0; do_acc = 1'b0; do_rel = 1'b0;
    code = CMD_NONE; known = 1'b0; fin = 1'b0;
    ev_reset_sent = 1'b0; ev_reboot = 1'b0; ev_ready = 1'b0; ev_hit = 1'b0;
    ev_full = 1'b0; ev_room = 1'b0; ev_miss = 1'b0;
    case (st_q)
      ST_PICK: begin
        if (!up[cur_q]) begin
          if (due[cur_q]) begin
            do_cmd = 1'b1; code = CMD_LINK_RESET; ev_reset_sent = 1'b1;
            kind_d = K_LINK; st_d = ST_WAIT;
          end else begin
            cur_d = ~cur_q;
          end
        end else if (full[cur_q]) begin
          do_cmd = 1'b1; code = CMD_ROOM_QUERY; kind_d = K_QUERY; st_d = ST_WAIT;
        end else if (tx_req[cur_q]) begin
          do_tx = 1'b1; st_d = ST_XMIT;
        end else begin
          do_cmd = 1'b1; code = CMD_POLL; kind_d = K_POLL; st_d = ST_WAIT;
        end
      end
      ST_XMIT: begin
        if (tx_done) begin
          kind_d = K_FRAME; st_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (hit) begin
          case (kind_q)
            K_LINK:
              if (rx_cmd == CMD_READY) begin known = 1'b1; ev_ready = 1'b1; end
            K_POLL:
              if (rx_cmd == CMD_NODATA) begin known = 1'b1; ev_hit = 1'b1; end
              else if (rx_cmd == CMD_FRAME_START) begin
                known = 1'b1; ev_hit = 1'b1; do_acc = 1'b1;
              end else if (rx_cmd == CMD_REBOOT) begin known = 1'b1; ev_reboot = 1'b1; end
            K_FRAME:
              if (rx_cmd == CMD_ACK_ROOM) begin known = 1'b1; ev_hit = 1'b1; do_rel = 1'b1; end
              else if (rx_cmd == CMD_ACK_FULL) begin
                known = 1'b1; ev_hit = 1'b1; ev_full = 1'b1; do_rel = 1'b1;
              end else if (rx_cmd == CMD_ACK_ERR) begin known = 1'b1; ev_hit = 1'b1; end
            default:
              if (rx_cmd == CMD_ACK_ROOM) begin known = 1'b1; ev_hit = 1'b1; ev_room = 1'b1; end
              else if (rx_cmd == CMD_ACK_FULL) begin
                known = 1'b1; ev_hit = 1'b1; ev_full = 1'b1;
              end
          endcase
        end
        if (known) begin
          if (do_acc) st_d = ST_RECV;
          else        fin = 1'b1;
        end else if (expired) begin
          ev_miss = 1'b1; fin = 1'b1;
        end
      end
      default: begin
        if (rx_done) fin = 1'b1;
      end
    endcase
    if (fin) begin
      st_d  = ST_PICK;
      cur_d = ~cur_q;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q       <= ST_PICK;
      kind_q     <= K_LINK;
      cur_q      <= 1'b0;
      cmd_valid  <= 1'b0;
      cmd_code   <= 4'h0;
      tx_start   <= 1'b0;
      rx_accept  <= 1'b0;
      tx_release <= 1'b0;
      slv        <= 1'b0;
    end else begin
      st_q       <= st_d;
      kind_q     <= kind_d;
      cur_q      <= cur_d;
      cmd_valid  <= do_cmd;
      cmd_code   <= code;
      tx_start   <= do_tx;
      rx_accept  <= do_acc;
      tx_release <= do_rel;
      slv        <= cur_q;
    end
  end
endmodule

// File: rtl/lnk_poll_master_chk.sv
module lnk_poll_master_chk #(
  parameter int RETRY_CYC = 250000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       rx_slave,
  input logic [3:0] rx_cmd,
  input logic       cmd_valid,
  input logic [3:0] cmd_code,
  input logic       tx_start,
  input logic       rx_accept,
  input logic       tx_release,
  input logic       slv
);
  localparam int GW = $clog2(RETRY_CYC + 1);

  logic [GW-1:0] gap_q [2];
  logic [1:0]    seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q[0] <= '0;
      gap_q[1] <= '0;
      seen_q   <= 2'b00;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (cmd_valid && cmd_code == 4'hB && slv == 1'(i)) begin
          assert_reset_spacing_R2: assert (!seen_q[i] || gap_q[i] >= GW'(RETRY_CYC - 1))
            else $error("link-reset to slave %0d came too early", i);
          gap_q[i]  <= '0;
          seen_q[i] <= 1'b1;
        end else if (gap_q[i] != GW'(RETRY_CYC)) begin
          gap_q[i] <= gap_q[i] + 1'b1;
        end
      end
    end
  end

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, tx_start, rx_accept, tx_release}));

  assert_code_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> cmd_code == 4'h0);

  assert_code_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_code == 4'hB || cmd_code == 4'h5 || cmd_code == 4'hC));

  assert_accept_follows_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |-> $past(rx_valid && rx_cmd == 4'h1 && rx_slave == slv));

  assert_release_follows_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_release |-> $past(rx_valid && (rx_cmd == 4'h8 || rx_cmd == 4'h9) && rx_slave == slv));

endmodule

bind lnk_poll_master lnk_poll_master_chk #(.RETRY_CYC(RETRY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_slave(rx_slave), .rx_cmd(rx_cmd),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .tx_start(tx_start),
  .rx_accept(rx_accept), .tx_release(tx_release), .slv(slv)
);

// File: tb/sim_lnk_poll_master.sv
`timescale 1ns/1ps
module sim_lnk_poll_master;
  localparam int TMO = 8;
  localparam int RT  = 40;
  localparam int ML  = 3;
  localparam int NCYC = 1900;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, rx_valid, rx_slave, tx_done, rx_done;
  logic [3:0] rx_cmd;
  logic [1:0] tx_req;
  logic       cmd_valid, tx_start, rx_accept, tx_release, slv;
  logic [3:0] cmd_code;

  lnk_poll_master #(.TIMEOUT_CYC(TMO), .RETRY_CYC(RT), .MISS_LIMIT(ML)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_slave(rx_slave), .rx_cmd(rx_cmd),
    .tx_req(tx_req), .tx_done(tx_done), .rx_done(rx_done),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .tx_start(tx_start),
    .rx_accept(rx_accept), .tx_release(tx_release), .slv(slv)
  );

  int    vec = 0, bad = 0;
  string tag = "R1";

  // reference model state
  int m_st = 0, m_kind = 0, m_cur = 0, m_tmr = 0;
  int m_up[2], m_full[2], m_miss[2], m_rty[2];
  int e_cv = 0, e_cc = 0, e_ts = 0, e_ra = 0, e_tr = 0, e_slv = 0;

  // scripted slaves
  int alive[2], data[2], room[2], boot[2], err[2], pkts[2];
  int rp_at = -1, rp_s = 0, rp_c = 0, td_at = -1, td_s = 0, rd_at = -1;
  int junk = 0;

  function automatic logic [8:0] exp_vec();
    return {1'(e_cv), 4'(e_cc), 1'(e_ts), 1'(e_ra), 1'(e_tr), 1'(e_slv)};
  endfunction

  task automatic check(input logic [8:0] act, input logic [8:0] exp, input string t, input int c);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d act=%h exp=%h", t, c, act, exp);
    end
  endtask

  task automatic model_step(input int rv, input int rs, input int rc, input int tdn, input int rdn,
                            input int t0, input int t1);
    int s, fin, known, setr0, setr1, treq;
    s = m_cur; fin = 0; known = 0; setr0 = 0; setr1 = 0;
    treq = (s == 0) ? t0 : t1;
    e_cv = 0; e_cc = 0; e_ts = 0; e_ra = 0; e_tr = 0; e_slv = m_cur;
    case (m_st)
      0: begin
        if (m_up[s] == 0) begin
          if (m_rty[s] == 0) begin
            e_cv = 1; e_cc = 11; m_kind = 0; m_st = 1; m_tmr = 0;
            if (s == 0) setr0 = 1; else setr1 = 1;
          end else m_cur = 1 - s;
        end else if (m_full[s] != 0) begin
          e_cv = 1; e_cc = 12; m_kind = 3; m_st = 1; m_tmr = 0;
        end else if (treq != 0) begin
          e_ts = 1; m_st = 2;
        end else begin
          e_cv = 1; e_cc = 5; m_kind = 1; m_st = 1; m_tmr = 0;
        end
      end
      2: if (tdn != 0) begin m_st = 1; m_kind = 2; m_tmr = 0; end
      1: begin
        if (rv != 0 && rs == s) begin
          if (m_kind == 0) begin
            if (rc == 15) begin known = 1; m_up[s] = 1; m_full[s] = 0; m_miss[s] = 0; end
          end else if (m_kind == 1) begin
            if (rc == 6) begin known = 1; m_miss[s] = 0; end
            else if (rc == 1) begin known = 1; m_miss[s] = 0; e_ra = 1; end
            else if (rc == 7) begin
              known = 1; m_up[s] = 0; m_full[s] = 0; m_miss[s] = 0;
              if (s == 0) setr0 = 1; else setr1 = 1;
            end
          end else if (m_kind == 2) begin
            if (rc == 8) begin known = 1; m_miss[s] = 0; e_tr = 1; end
            else if (rc == 9) begin known = 1; m_miss[s] = 0; m_full[s] = 1; e_tr = 1; end
            else if (rc == 10) begin known = 1; m_miss[s] = 0; end
          end else begin
            if (rc == 8) begin known = 1; m_miss[s] = 0; m_full[s] = 0; end
            else if (rc == 9) begin known = 1; m_miss[s] = 0; m_full[s] = 1; end
          end
        end
        if (known != 0) begin
          if (e_ra != 0) m_st = 3; else fin = 1;
        end else if (m_tmr == TMO - 1) begin
          fin = 1;
          if (m_up[s] != 0) begin
            if (m_miss[s] == ML - 1) begin m_up[s] = 0; m_full[s] = 0; m_miss[s] = 0; end
            else m_miss[s]++;
          end
        end else m_tmr++;
      end
      default: if (rdn != 0) fin = 1;
    endcase
    if (fin != 0) begin m_st = 0; m_cur = 1 - s; end
    if (setr0 != 0) m_rty[0] = RT - 1; else if (m_rty[0] > 0) m_rty[0]--;
    if (setr1 != 0) m_rty[1] = RT - 1; else if (m_rty[1] > 0) m_rty[1]--;
  endtask

  task automatic slaves_react(input int c);
    int s;
    s = e_slv;
    if (e_cv != 0 && alive[s] != 0) begin
      rp_at = c + 2; rp_s = s;
      if (e_cc == 11) rp_c = 15;
      else if (e_cc == 12) rp_c = (room[s] > 0) ? 8 : 9;
      else if (boot[s] != 0) begin rp_c = 7; boot[s] = 0; alive[s] = 0; end
      else if (data[s] > 0) begin rp_c = 1; data[s]--; end
      else rp_c = 6;
    end
    if (e_ts != 0) begin td_at = c + 3; td_s = s; end
    if (e_ra != 0) rd_at = c + 4;
    if (e_tr != 0 && pkts[s] > 0) pkts[s]--;
  endtask

  task automatic phase(input int c);
    case (c)
      0:    tag = "R2";
      120:  alive[0] = 1;
      200:  tag = "R3";
      300:  alive[1] = 1;
      420:  begin tag = "R4"; data[0] = 2; data[1] = 1; end
      520:  begin tag = "R5"; pkts[0] = 2; room[0] = 5; end
      640:  begin tag = "R6"; room[1] = 1; pkts[1] = 3; end
      760:  room[1] = 4;
      900:  begin tag = "R7"; err[0] = 1; pkts[0] = 1; end
      1000: begin tag = "R8"; boot[1] = 1; end
      1080: alive[1] = 1;
      1200: begin tag = "R9"; junk = 1; end
      1400: begin tag = "R10"; junk = 0; alive[0] = 0; pkts[1] = 2; data[1] = 3; end
      1600: begin
        tag = "R11"; alive[0] = 1; data[0] = 2; data[1] = 2;
        pkts[0] = 2; pkts[1] = 2; room[0] = 3; room[1] = 3;
      end
      default: ;
    endcase
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_up[i] = 0; m_full[i] = 0; m_miss[i] = 0; m_rty[i] = 0;
      alive[i] = 0; data[i] = 0; room[i] = 0; boot[i] = 0; err[i] = 0; pkts[i] = 0;
    end
    rst_n = 1'b0; rx_valid = 1'b0; rx_slave = 1'b0; rx_cmd = 4'h0;
    tx_req = 2'b00; tx_done = 1'b0; rx_done = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs idle while in reset
    check({cmd_valid, cmd_code, tx_start, rx_accept, tx_release, slv}, 9'h000, "R1", -1);
    rst_n = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      phase(c);
      rx_valid = 1'b0; rx_slave = 1'b0; rx_cmd = 4'h0;
      if (rp_at == c) begin
        rx_valid = 1'b1; rx_slave = 1'(rp_s); rx_cmd = 4'(rp_c);
      end else if (junk != 0 && c % 5 == 0) begin
        rx_valid = 1'b1; rx_slave = 1'((c / 5) % 2);
        rx_cmd = (c % 3 == 0) ? 4'h7 : ((c % 3 == 1) ? 4'hF : 4'h9);
      end
      tx_done = (td_at == c);
      if (td_at == c && alive[td_s] != 0) begin
        rp_at = c + 2; rp_s = td_s;
        if (err[td_s] != 0) begin rp_c = 10; err[td_s] = 0; end
        else begin
          if (room[td_s] > 0) room[td_s]--;
          rp_c = (room[td_s] > 0) ? 8 : 9;
        end
      end
      rx_done = (rd_at == c);
      tx_req = {pkts[1] > 0, pkts[0] > 0};
      if (c >= 2) begin
        model_step(int'(rx_valid), int'(rx_slave), int'(rx_cmd), int'(tx_done), int'(rx_done),
                   int'(tx_req[0]), int'(tx_req[1]));
        slaves_react(c);
      end
      @(negedge clk);
      if (c == 2)
        check({cmd_valid, cmd_code, slv}, {1'b1, 4'hB, 1'b0}, "R1", c);
      check({cmd_valid, cmd_code, tx_start, rx_accept, tx_release, slv}, exp_vec(), tag, c);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule